// File: doc/BRIEF.md
# Two-Channel Filterless PWM Modulator

This block turns one signed audio sample per channel into two pulse-width modulated drive bits per channel, meant for a full bridge that runs with no LC reconstruction filter. The positive and negative bits of a channel move their duties in opposite directions around one half. At zero input both bits carry the same 50% waveform, so the voltage across the load is zero for most of each switching period and only a short difference pulse remains as the sample grows.

A free-running counter forms the carrier, and both channels share it. A duty limit acts as a virtual supply rail below the real one and so caps the output power. A mono select drives both channels from the right-channel sample, in phase, so that the two bridges can be wired in parallel. An enable lowers every output-enable bit so that the pads go high-impedance. Sample and limit values are taken in only at the boundary of a carrier period, which keeps partial pulses out of the output.

With the default of 64 steps per period and a 32 MHz clock, the switching frequency is 500 kHz. The 400 to 600 kHz window is met with clocks from 25.6 to 38.4 MHz.

Top module: `amp_pwm_modulator`

## Requirements
- R1: While reset is asserted, all four drive bits and all four bits of `drv_oe` are 0.
- R2: The carrier repeats every PERIOD clocks (default 64). At a constant mid-scale duty each drive bit shows exactly one rising edge per PERIOD clocks.
- R3: At zero input the positive and negative bits of a channel are high for PERIOD/2 clocks of each period and match cycle for cycle. Both channels run on the same carrier phase.
- R4: Over each period the positive bit is high for P = PERIOD/2 + floor(s*(PERIOD/2)/2^(SAMPLE_W-1)) clocks, where s is the signed sample, and the negative bit for PERIOD - P clocks. With the defaults, +127 gives 63/1, -128 gives 0/64, -1 gives 31/33 and +64 gives 48/16.
- R5: A limit L between PERIOD/2 and PERIOD-1 clamps P to the range [PERIOD-L, L]. A limit below PERIOD/2 acts as PERIOD/2 and forces 50% on both bits. A limit of PERIOD or more applies no clamp.
- R6: When `mono` is 1, both channels use the right-channel sample and their bits are identical. The left-channel sample has no effect.
- R7: Sample and limit values are captured only when the carrier wraps. A change that is undone before the wrap has no effect on any output.
- R8: `drv_oe` is 4'b1111 one clock after `en` is 1 and 4'b0000 one clock after `en` is 0. The bit order is bit0 left positive, bit1 left negative, bit2 right positive, bit3 right negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; 0 lowers every output-enable bit |
| mono | input | 1 | 1 drives both channels from the right sample |
| limit | input | LIM_W | Maximum high count per period (power limit) |
| smp_l | input | SAMPLE_W | Signed left-channel sample |
| smp_r | input | SAMPLE_W | Signed right-channel sample |
| drv_l_p | output | 1 | Left positive drive bit |
| drv_l_n | output | 1 | Left negative drive bit |
| drv_r_p | output | 1 | Right positive drive bit |
| drv_r_n | output | 1 | Right negative drive bit |
| drv_oe | output | 4 | Output enable per drive bit (1 = driven) |

## Verification
The high time of each bit is counted over one full period for a zero sample, both full-scale extremes, a one-LSB negative value and a mid positive value. Together these show the 50% rest point, the rounding direction, saturation at 0 and PERIOD, and that the two channels are independent. Limits inside, below and above the clamp range show whether the clamp is symmetric, whether a low limit falls back to 50%, and whether a high limit applies no clamp. Mono with different left and right samples shows where each channel takes its sample from. A short excursion of the sample and the limit placed inside a period shows whether capture happens only at the wrap. Toggling the enable checks the output-enable timing.

// File: rtl/amp_pwm_pkg.sv
package amp_pwm_pkg;

  // index of each drive bit inside the output-enable vector
  localparam int OE_L_P = 0;
  localparam int OE_L_N = 1;
  localparam int OE_R_P = 2;
  localparam int OE_R_N = 3;
  localparam int NUM_CH = 2;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int PERIOD = 64,
  parameter int CNT_W  = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/pwm_duty_calc.sv
module pwm_duty_calc
  import amp_pwm_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int PERIOD   = 64,
  parameter int CNT_W    = $clog2(PERIOD + 1),
  parameter int LIM_W    = CNT_W
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [LIM_W-1:0]    limit,
  output logic        [CNT_W-1:0]    duty_p,
  output logic        [CNT_W-1:0]    duty_n
);

  localparam int HALF = PERIOD / 2;

  // signed offset from half duty: floor(s * HALF / 2^(SAMPLE_W-1))
  function automatic int scale_sample(input logic signed [SAMPLE_W-1:0] s);
    int prod;
    prod = int'(s) * HALF;
    return prod >>> (SAMPLE_W - 1);
  endfunction

  // effective ceiling: never below half, never above a full period
  function automatic int eff_ceiling(input logic [LIM_W-1:0] l);
    return clamp_int(int'(l), HALF, PERIOD);
  endfunction

  int raw_p;
  int ceil_p;
  int sat_p;

  always_comb begin
    raw_p  = HALF + scale_sample(sample);
    ceil_p = eff_ceiling(limit);
    sat_p  = clamp_int(raw_p, PERIOD - ceil_p, ceil_p);
    duty_p = CNT_W'(sat_p);
    duty_n = CNT_W'(PERIOD - sat_p);
  end

endmodule

// File: rtl/pwm_channel_out.sv
module pwm_channel_out #(
  parameter int PERIOD = 64,
  parameter int CNT_W  = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] next_p,
  input  logic [CNT_W-1:0] next_n,
  output logic             out_p,
  output logic             out_n
);

  localparam logic [CNT_W-1:0] HALF_D = CNT_W'(PERIOD / 2);

  logic [CNT_W-1:0] cur_p;
  logic [CNT_W-1:0] cur_n;

  // new duty taken only at the carrier boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_p <= HALF_D;
      cur_n <= HALF_D;
    end else if (wrap) begin
      cur_p <= next_p;
      cur_n <= next_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_p <= 1'b0;
      out_n <= 1'b0;
    end else begin
      out_p <= (cnt < cur_p);
      out_n <= (cnt < cur_n);
    end
  end

  assert_capture_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> ($stable(cur_p) && $stable(cur_n)));

  assert_duty_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cur_p) + 32'(cur_n)) == PERIOD);

  assert_in_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_p != out_n) |-> ($past(cur_p) != $past(cur_n)));

endmodule

// File: rtl/amp_pwm_modulator.sv
module amp_pwm_modulator
  import amp_pwm_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int PERIOD   = 64,
  parameter int CNT_W    = $clog2(PERIOD + 1),
  parameter int LIM_W    = CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                mono,
  input  logic [LIM_W-1:0]    limit,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  output logic                drv_l_p,
  output logic                drv_l_n,
  output logic                drv_r_p,
  output logic                drv_r_n,
  output logic [3:0]          drv_oe
);

  localparam int HALF = PERIOD / 2;

  logic [CNT_W-1:0]    cnt;
  logic                wrap;
  logic [SAMPLE_W-1:0] ch_smp [NUM_CH];
  logic [CNT_W-1:0]    ch_dp  [NUM_CH];
  logic [CNT_W-1:0]    ch_dn  [NUM_CH];
  logic                ch_op  [NUM_CH];
  logic                ch_on  [NUM_CH];

  pwm_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt),
    .wrap (wrap)
  );

  // channel 0 = left, channel 1 = right; mono routes right into both
  assign ch_smp[0] = mono ? smp_r : smp_l;
  assign ch_smp[1] = smp_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_duty_calc #(
      .SAMPLE_W(SAMPLE_W), .PERIOD(PERIOD), .CNT_W(CNT_W), .LIM_W(LIM_W)
    ) u_calc (
      .sample(ch_smp[c]),
      .limit (limit),
      .duty_p(ch_dp[c]),
      .duty_n(ch_dn[c])
    );

    pwm_channel_out #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .wrap  (wrap),
      .cnt   (cnt),
      .next_p(ch_dp[c]),
      .next_n(ch_dn[c]),
      .out_p (ch_op[c]),
      .out_n (ch_on[c])
    );
  end

  assign drv_l_p = ch_op[0];
  assign drv_l_n = ch_on[0];
  assign drv_r_p = ch_op[1];
  assign drv_r_n = ch_on[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_oe <= 4'b0000;
    else        drv_oe <= {4{en}};
  end

  assert_oe_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (drv_oe == 4'b1111));

  assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (drv_oe == 4'b0000));

  assert_mono_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mono |-> (ch_dp[0] == ch_dp[1]) && (ch_dn[0] == ch_dn[1]));

  assert_clamp_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(limit) >= HALF && int'(limit) < PERIOD) |->
      (int'(ch_dp[0]) <= int'(limit)) && (int'(ch_dn[0]) <= int'(limit)) &&
      (int'(ch_dp[1]) <= int'(limit)) && (int'(ch_dn[1]) <= int'(limit)));

endmodule

// File: tb/test_amp_pwm_modulator.sv
module test_amp_pwm_modulator;

  localparam int SAMPLE_W = 8;
  localparam int PERIOD   = 64;
  localparam int HALF     = PERIOD / 2;
  localparam int CNT_W    = $clog2(PERIOD + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                en = 1'b0;
  logic                mono = 1'b0;
  logic [CNT_W-1:0]    limit = '0;
  logic [SAMPLE_W-1:0] smp_l = '0;
  logic [SAMPLE_W-1:0] smp_r = '0;
  logic drv_l_p, drv_l_n, drv_r_p, drv_r_n;
  logic [3:0] drv_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  amp_pwm_modulator #(.SAMPLE_W(SAMPLE_W), .PERIOD(PERIOD)) i_amp_pwm_modulator (
    .clk(clk), .rst_n(rst_n), .en(en), .mono(mono), .limit(limit),
    .smp_l(smp_l), .smp_r(smp_r),
    .drv_l_p(drv_l_p), .drv_l_n(drv_l_n), .drv_r_p(drv_r_p), .drv_r_n(drv_r_n),
    .drv_oe(drv_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected positive high count, written with division instead of shifts
  function automatic int exp_pos(input int s, input int lim);
    int num, q, ceil_v, v;
    num = s * HALF;
    if (num >= 0) q = num / 128;
    else          q = -((-num + 127) / 128);
    ceil_v = lim;
    if (ceil_v < HALF)   ceil_v = HALF;
    if (ceil_v > PERIOD) ceil_v = PERIOD;
    v = HALF + q;
    if (v > ceil_v)          v = ceil_v;
    if (v < PERIOD - ceil_v) v = PERIOD - ceil_v;
    return v;
  endfunction

  int hlp, hln, hrp, hrn, rises, diff_lr, diff_pn;

  task automatic measure();
    logic prev;
    hlp = 0; hln = 0; hrp = 0; hrn = 0; rises = 0; diff_lr = 0; diff_pn = 0;
    prev = drv_l_p;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      hlp += int'(drv_l_p); hln += int'(drv_l_n);
      hrp += int'(drv_r_p); hrn += int'(drv_r_n);
      if (drv_l_p && !prev) rises++;
      if (drv_l_p != drv_r_p || drv_l_n != drv_r_n) diff_lr++;
      if (drv_l_p != drv_l_n) diff_pn++;
      prev = drv_l_p;
    end
  endtask

  task automatic apply(input int sl, input int sr, input int lim, input bit m);
    @(negedge clk);
    smp_l = SAMPLE_W'(sl); smp_r = SAMPLE_W'(sr);
    limit = CNT_W'(lim);   mono = m;
    repeat (3 * PERIOD) @(negedge clk);
  endtask

  task automatic check_duties(input int sl, input int sr, input int lim, input string req);
    int el, er;
    el = exp_pos(sl, lim);
    er = exp_pos(sr, lim);
    measure();
    check(hlp == el,          {req, " left pos"},  hlp, el);
    check(hln == PERIOD - el, {req, " left neg"},  hln, PERIOD - el);
    check(hrp == er,          {req, " right pos"}, hrp, er);
    check(hrn == PERIOD - er, {req, " right neg"}, hrn, PERIOD - er);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(drv_l_p == 0 && drv_l_n == 0, "R1 left bits", int'({drv_l_p, drv_l_n}), 0);
    check(drv_r_p == 0 && drv_r_n == 0, "R1 right bits", int'({drv_r_p, drv_r_n}), 0);
    check(drv_oe == 4'b0000, "R1 oe", int'(drv_oe), 0);
  endtask

  task automatic t_zero();
    apply(0, 0, 127, 0);
    check_duties(0, 0, 127, "R3 zero");
    check(diff_pn == 0, "R3 pos/neg in phase", diff_pn, 0);
    check(diff_lr == 0, "R3 channels aligned", diff_lr, 0);
    check(rises == 1, "R2 one edge per period", rises, 1);
    check(drv_oe == 4'b1111, "R8 oe enabled", int'(drv_oe), 15);
  endtask

  task automatic t_mapping();
    apply(127, 64, 127, 0);
    check_duties(127, 64, 127, "R4 +full/+half");
    apply(-128, -1, 127, 0);
    check_duties(-128, -1, 127, "R4 -full/-1");
  endtask

  task automatic t_clamp();
    apply(127, -128, 48, 0);
    check_duties(127, -128, 48, "R5 limit 48");
    check(hlp == 48, "R5 ceiling left", hlp, 48);
    apply(127, -128, 20, 0);
    check_duties(127, -128, 20, "R5 low limit half");
    apply(127, -128, 64, 0);
    check_duties(127, -128, 64, "R5 no clamp");
  endtask

  task automatic t_mono();
    apply(-128, 100, 127, 1);
    check_duties(100, 100, 127, "R6 mono");
    check(diff_lr == 0, "R6 mono identical", diff_lr, 0);
    mono = 1'b0;
  endtask

  task automatic t_capture();
    logic prev;
    apply(0, 0, 127, 0);
    prev = drv_l_p;
    // find the first clock of a period: rising edge of the left positive bit
    for (int k = 0; k < 2 * PERIOD; k++) begin
      @(negedge clk);
      if (drv_l_p && !prev) break;
      prev = drv_l_p;
    end
    smp_l = SAMPLE_W'(127); smp_r = SAMPLE_W'(-128); limit = CNT_W'(40);
    repeat (8) @(negedge clk);
    smp_l = '0; smp_r = '0; limit = CNT_W'(127);
    measure();
    check(hlp == HALF, "R7 left pos unchanged", hlp, HALF);
    check(hrn == HALF, "R7 right neg unchanged", hrn, HALF);
    measure();
    check(hln == HALF && hrp == HALF, "R7 next period unchanged", hln, HALF);
  endtask

  task automatic t_enable();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check(drv_oe == 4'b0000, "R8 oe off", int'(drv_oe), 0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    check(drv_oe == 4'b1111, "R8 oe back on", int'(drv_oe), 15);
  endtask

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1'b1; en = 1'b1;
    t_zero();
    t_mapping();
    t_clamp();
    t_mono();
    t_capture();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule